// File: doc/BRIEF.md
# Dual Clock Observation Mux

This block brings internal clocks out to two test pins so they can be looked at on a scope or a tester. Each of the two channels picks one of nine internal clock nets, or a constant low, and can pass the chosen clock straight through. It can also divide the clock by 2, 4 or 8 before driving its observation output. When dividing, the channel's counter can advance on either the rising or the falling edge of the chosen source.

Both channels are set through one 16-bit control word. The word is written in a single cycle of the register clock and can be read back. Channel 0 uses byte 0 and channel 1 uses byte 1. Within each byte, bits [3:0] hold the source code, bits [5:4] hold the divide code and bit 6 is the edge bit. Bit 7 is reserved and reads as 0. A change to any field of a channel clears that channel's divider counter. The divided output therefore restarts from a known phase.

Top module: `clkobs_mux`

## Requirements
- R1: A source code of 0 (byte bits [3:0]) holds that channel's output at 0 whatever the clock inputs do.
- R2: Source codes 1 to 9 route `src_clk[0]` to `src_clk[8]` respectively, in that order: low-speed oscillator, main oscillator, crystal oscillator, external clock, high-speed root, low-speed root, system clock, pump clock, sleep-controller clock.
- R3: Source codes 10 to 15 behave exactly like code 0.
- R4: Divide code (byte bits [5:4]) 0 passes the selected clock through. Codes 1, 2 and 3 give that clock divided by 2, 4 and 8 with a 50% duty cycle. After a counter clear the divided output is 0 and first goes high after 1, 2 or 4 counting edges.
- R5: With a non-zero divide code, edge bit (byte bit 6) = 0 advances the counter on rising source edges and 1 advances it on falling source edges.
- R6: With divide code 0 the edge bit has no effect: the output equals the source, not its inverse.
- R7: The two channels are independent. A write that leaves one channel's byte unchanged does not disturb that channel's output or counter.
- R8: Any write that changes a field of a channel clears that channel's divider counter. Rewriting the same value leaves the counter running.
- R9: After reset `cfg_rdata` is 0 and both outputs are 0. A write appears on `cfg_rdata` one register clock later with bit 7 of each byte reading 0. Without a write, `cfg_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word to write, one byte per channel |
| cfg_rdata | output | 16 | Current control word |
| src_clk | input | 9 | Internal clock nets, index 0 is source code 1 |
| obs_clk | output | 2 | Observation outputs, one per channel |

## Verification
The bench drives the source nets by hand, so every counting edge is placed deliberately. It targets the codes past the last real source, which a design indexing the source vector without a range check would route to a stray or undefined net. It also checks the half-pulse phase between rising and falling counting, where a design that ignored or inverted the edge bit would show the count one edge early or late. The pass-through case with the edge bit set is checked as well, since a design that applied the edge bit there would drive out an inverted clock. Clear-on-change is probed both by a real change and by rewriting the same value: a design that cleared on every write, or on a write to the other channel, would lose its count.

// File: rtl/clkobs_pkg.sv
package clkobs_pkg;
   localparam int SEL_W  = 4;
   localparam int DIV_W  = 2;
   localparam int STRIDE = 8;

   typedef struct packed {
      logic               falling;
      logic [DIV_W-1:0]   div;
      logic [SEL_W-1:0]   sel;
   } chan_cfg_t;

   localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/clkobs_cfg.sv
module clkobs_cfg
   import clkobs_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [NUM_CH*STRIDE-1:0]   wdata,
   output chan_cfg_t [NUM_CH-1:0]     cfg,
   output logic [NUM_CH-1:0]          clr
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      chan_cfg_t nxt;
      assign nxt = chan_cfg_t'(wdata[c*STRIDE +: CFG_W]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg[c] <= '0;
            clr[c] <= 1'b1;
         end else begin
            clr[c] <= wr_en && (nxt != cfg[c]);
            if (wr_en) cfg[c] <= nxt;
         end
      end
   end
endmodule

// File: rtl/clkobs_srcmux.sv
module clkobs_srcmux
   import clkobs_pkg::*;
#(
   parameter int NUM_SRC = 9
) (
   input  logic [NUM_SRC-1:0] src,
   input  logic [SEL_W-1:0]   sel,
   output logic               out
);
   always_comb begin
      out = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel == SEL_W'(i + 1)) out = src[i];
      end
   end
endmodule

// File: rtl/clkobs_div.sv
module clkobs_div
   import clkobs_pkg::*;
#(
   parameter bit EDGE_SEL_EN = 1'b1
) (
   input  logic             clk_in,
   input  logic             falling,
   input  logic [DIV_W-1:0] div_code,
   input  logic             clr,
   output logic             clk_out
);
   localparam int CNT_W = (1 << DIV_W) - 1;

   logic             cnt_clk;
   logic [CNT_W-1:0] cnt;

   if (EDGE_SEL_EN) begin : g_edge
      assign cnt_clk = clk_in ^ falling;
   end else begin : g_rise
      logic unused_fall;
      assign unused_fall = falling;
      assign cnt_clk = clk_in;
   end

   always_ff @(posedge cnt_clk or posedge clr) begin
      if (clr) cnt <= '0;
      else     cnt <= cnt + 1'b1;
   end

   always_comb begin
      clk_out = clk_in;
      for (int k = 1; k <= CNT_W; k++) begin
         if (div_code == DIV_W'(k)) clk_out = cnt[k-1];
      end
   end
endmodule

// File: rtl/clkobs_mux.sv
module clkobs_mux
   import clkobs_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int NUM_SRC     = 9,
   parameter bit EDGE_SEL_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr,
   input  logic [NUM_CH*STRIDE-1:0] cfg_wdata,
   output logic [NUM_CH*STRIDE-1:0] cfg_rdata,
   input  logic [NUM_SRC-1:0]       src_clk,
   output logic [NUM_CH-1:0]        obs_clk
);
   if (NUM_SRC >= (1 << SEL_W)) begin : g_bad_src
      $error("NUM_SRC does not fit the source code width");
   end
   if (CFG_W > STRIDE) begin : g_bad_stride
      $error("channel fields exceed the per-channel stride");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("at least one channel is required");
   end

   chan_cfg_t [NUM_CH-1:0] cfg;
   logic [NUM_CH-1:0]      clr;

   clkobs_cfg #(.NUM_CH(NUM_CH)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_wr),
      .wdata (cfg_wdata),
      .cfg   (cfg),
      .clr   (clr)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic picked;

      assign cfg_rdata[c*STRIDE +: STRIDE] = STRIDE'(cfg[c]);

      clkobs_srcmux #(.NUM_SRC(NUM_SRC)) u_mux (
         .src (src_clk),
         .sel (cfg[c].sel),
         .out (picked)
      );

      clkobs_div #(.EDGE_SEL_EN(EDGE_SEL_EN)) u_div (
         .clk_in   (picked),
         .falling  (cfg[c].falling),
         .div_code (cfg[c].div),
         .clr      (clr[c]),
         .clk_out  (obs_clk[c])
      );
   end
endmodule

// File: rtl/clkobs_mux_chk.sv
module clkobs_mux_chk
   import clkobs_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int NUM_SRC = 9
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_wr,
   input logic [NUM_CH*STRIDE-1:0] cfg_wdata,
   input logic [NUM_CH*STRIDE-1:0] cfg_rdata,
   input logic [NUM_SRC-1:0]       src_clk,
   input logic [NUM_CH-1:0]        obs_clk
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [SEL_W-1:0] sel;
      logic [DIV_W-1:0] div;
      logic [DIV_W-1:0] wdiv;
      logic [CFG_W-1:0] rfld;
      logic [CFG_W-1:0] wfld;

      assign sel  = cfg_rdata[c*STRIDE +: SEL_W];
      assign div  = cfg_rdata[c*STRIDE + SEL_W +: DIV_W];
      assign wdiv = cfg_wdata[c*STRIDE + SEL_W +: DIV_W];
      assign rfld = cfg_rdata[c*STRIDE +: CFG_W];
      assign wfld = cfg_wdata[c*STRIDE +: CFG_W];

      // R1 and R3: disabled and unused codes give a low output
      p_off_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == '0 || int'(sel) > NUM_SRC) |-> (obs_clk[c] == 1'b0));

      // R2, R4, R6: undivided output follows the chosen source
      p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (sel != '0 && int'(sel) <= NUM_SRC && div == '0)
            |-> (obs_clk[c] == src_clk[sel - SEL_W'(1)]));

      // R8: a changing write leaves a divided output at its cleared phase
      p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_wr && wfld != rfld && wdiv != '0) |=> (obs_clk[c] == 1'b0));

      // R9: written byte read back with the reserved bits at 0
      p_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_wr |=> (cfg_rdata[c*STRIDE +: STRIDE] ==
                     STRIDE'($past(cfg_wdata[c*STRIDE +: CFG_W]))));
   end

   // R9: without a write the control word holds
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(cfg_rdata));
endmodule

bind clkobs_mux clkobs_mux_chk #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .src_clk   (src_clk),
   .obs_clk   (obs_clk)
);

// File: tb/clkobs_mux_test.sv
module clkobs_mux_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic [8:0]  src_clk = '0;
   logic [1:0]  obs_clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   clkobs_mux uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .src_clk   (src_clk),
      .obs_clk   (obs_clk)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] chan_byte(input int sel, input int dv, input bit fall);
      return {1'b0, fall, 2'(dv), 4'(sel)};
   endfunction

   task automatic wr(input logic [15:0] data);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = data;
      @(negedge clk);
      cfg_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      #1;
      chk("R9 reset rdata", cfg_rdata, 16'h0000);
      chk("R1 reset outputs", {14'b0, obs_clk}, 16'h0000);
   endtask

   task automatic t_select();
      for (int ch = 0; ch < 2; ch++) begin
         for (int code = 0; code < 16; code++) begin
            logic [7:0] b;
            bit valid;
            b = chan_byte(code, 0, 1'b0);
            valid = (code >= 1 && code <= 9);
            wr(ch == 0 ? {8'h00, b} : {b, 8'h00});
            if (valid) begin
               src_clk = 9'(1) << (code - 1);
               #1;
               chk($sformatf("R2 ch%0d code%0d high", ch, code), 16'(obs_clk[ch]), 16'h1);
               src_clk = ~(9'(1) << (code - 1));
               #1;
               chk($sformatf("R2 ch%0d code%0d low", ch, code), 16'(obs_clk[ch]), 16'h0);
            end else begin
               src_clk = '1;
               #1;
               chk($sformatf("%s ch%0d code%0d", code == 0 ? "R1" : "R3", ch, code),
                   16'(obs_clk[ch]), 16'h0);
            end
            src_clk = '0;
         end
      end
   endtask

   task automatic t_divide(input int ch, input int dv, input bit fall);
      int sel;
      logic [7:0] b;
      sel = 3 + dv;
      b = chan_byte(sel, dv, fall);
      src_clk = '0;
      wr(ch == 0 ? {8'h00, b} : {b, 8'h00});
      #1;
      chk($sformatf("R4 ch%0d div%0d cleared", ch, dv), 16'(obs_clk[ch]), 16'h0);
      for (int m = 1; m <= 16; m++) begin
         int after_rise;
         src_clk[sel-1] = 1'b1;
         #2;
         after_rise = fall ? m - 1 : m;
         chk($sformatf("R5 ch%0d div%0d fall%0d rise%0d", ch, dv, fall, m),
             16'(obs_clk[ch]), 16'((after_rise >> (dv - 1)) & 1));
         src_clk[sel-1] = 1'b0;
         #2;
         chk($sformatf("R4 ch%0d div%0d fall%0d pulse%0d", ch, dv, fall, m),
             16'(obs_clk[ch]), 16'((m >> (dv - 1)) & 1));
      end
   endtask

   task automatic t_edge_passthru();
      wr({8'h00, chan_byte(5, 0, 1'b1)});
      src_clk = 9'b0_0001_0000;
      #1;
      chk("R6 edge ignored high", 16'(obs_clk[0]), 16'h1);
      src_clk = '0;
      #1;
      chk("R6 edge ignored low", 16'(obs_clk[0]), 16'h0);
   endtask

   task automatic t_indep();
      logic [7:0] b0;
      b0 = chan_byte(1, 1, 1'b0);
      src_clk = '0;
      wr({chan_byte(2, 1, 1'b0), b0});
      for (int m = 0; m < 3; m++) begin
         src_clk[0] = 1'b1; #2; src_clk[0] = 1'b0; #2;
      end
      chk("R7 ch0 after three edges", 16'(obs_clk[0]), 16'h1);
      wr({chan_byte(2, 2, 1'b0), b0});
      chk("R7 ch0 kept over ch1 write", 16'(obs_clk[0]), 16'h1);
      src_clk[1] = 1'b1; #2; src_clk[1] = 1'b0; #2;
      chk("R7 ch0 kept over ch1 edge", 16'(obs_clk[0]), 16'h1);
      chk("R7 ch1 one edge at div4", 16'(obs_clk[1]), 16'h0);
      src_clk[1] = 1'b1; #2; src_clk[1] = 1'b0; #2;
      chk("R7 ch1 two edges at div4", 16'(obs_clk[1]), 16'h1);
   endtask

   task automatic t_clear();
      logic [15:0] w;
      w = {8'h00, chan_byte(7, 1, 1'b0)};
      src_clk = '0;
      wr(w);
      src_clk[6] = 1'b1; #2; src_clk[6] = 1'b0; #2;
      chk("R8 one edge before rewrite", 16'(obs_clk[0]), 16'h1);
      wr(w);
      chk("R8 same-value rewrite keeps count", 16'(obs_clk[0]), 16'h1);
      src_clk[6] = 1'b1; #2; src_clk[6] = 1'b0; #2;
      chk("R8 count continues to two", 16'(obs_clk[0]), 16'h0);
      src_clk[6] = 1'b1; #2; src_clk[6] = 1'b0; #2;
      chk("R8 count at three", 16'(obs_clk[0]), 16'h1);
      wr({8'h00, chan_byte(7, 1, 1'b1)});
      chk("R8 edge change clears", 16'(obs_clk[0]), 16'h0);
   endtask

   task automatic t_readback();
      wr(16'hFFFF);
      chk("R9 reserved bits read 0", cfg_rdata, 16'h7F7F);
      wr(16'h2A15);
      chk("R9 readback pattern", cfg_rdata, 16'h2A15);
      repeat (3) @(negedge clk);
      chk("R9 holds without write", cfg_rdata, 16'h2A15);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_select();
      for (int ch = 0; ch < 2; ch++)
         for (int dv = 1; dv <= 3; dv++)
            for (int f = 0; f < 2; f++)
               t_divide(ch, dv, f[0]);
      t_edge_passthru();
      t_indep();
      t_clear();
      t_readback();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule